// File: doc/BRIEF.md
# Shadow Atomic Region Classifier

This block sits beside the load/store path of a core that runs monitoring code inside an atomic region. A region-open instruction starts the region and a region-close instruction ends it. Inside the region, the first memory access is the original access. Every later access that reuses the original's virtual address and access type is a shadow access. Shadow accesses carry nothing in their encoding that marks them; position and address alone identify them.

Each shadow access gets an index that picks which shadow value it reaches: 1 for the first, 2 for the second, and so on up to a configurable ceiling. Shadow accesses are flagged to bypass coherence, so they raise no requests, invalidations or misses. A per-core ready flag, read by the coherence logic, is low while a region is open.

Accesses that break the pattern are still issued as ordinary accesses, and an error pulse is raised for them. Such accesses are a different address, a different type, a nested open, or too many shadows. All outputs are registered and appear one clock after the instruction is presented.

Top module: `shadow_region_classifier`

## Requirements
- R1: The ready output is 1 after reset. A region-open (class code 1) accepted with no region open drives ready to 0. A region-close (class code 2) with a region open drives it back to 1. Each change is visible on the cycle after the instruction.
- R2: The first load (class 3) or store (class 4) after a region-open is tagged original (tag code 1) with shadow index 0.
- R3: An access is tagged shadow (tag code 2) when it is inside an open region after the original, has the original's address and has the original's type. Successive shadow accesses in one region get indices 1, 2, 3 and so on.
- R4: The coherence-bypass output is 1 exactly for accesses tagged shadow, and 0 for every other output cycle.
- R5: A same-address access whose type (load or store) differs from the original raises type_err. It is tagged plain (tag code 0) with index 0, and it does not advance the shadow count.
- R6: An in-region access, after the original, whose address differs from the original raises addr_err. It is tagged plain with index 0, and the shadow count is left unchanged. The address check takes precedence over the type check.
- R7: A region-open while a region is already open raises nest_err. The open region, its original access and its shadow count are unchanged.
- R8: A region-close with no region open is ignored: ready stays 1, and no flag or access is reported.
- R9: Once the count has reached MAX_SHADOW, further shadow accesses report index MAX_SHADOW and raise ovf_err.
- R10: A region-close clears the shadow count, so the next region's first shadow access gets index 1. Loads and stores outside any region are tagged plain.
- R11: acc_valid is 1 only for a presented load or store. Cycles with op_valid low, and instructions of class 0 (other), produce acc_valid 0, tag plain, index 0 and no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An instruction is presented this cycle |
| op_class | input | 3 | 0 other, 1 region-open, 2 region-close, 3 load, 4 store |
| op_addr | input | AW | Virtual address of a load or store |
| acc_valid | output | 1 | Registered: a load or store was classified |
| acc_tag | output | 2 | 0 plain, 1 original, 2 shadow |
| shadow_idx | output | IW | Shadow value index, 0 unless tag is shadow |
| coh_bypass | output | 1 | Access must not take part in coherence |
| ready | output | 1 | Per-core ready flag, low while a region is open |
| nest_err | output | 1 | Region-open seen inside an open region |
| addr_err | output | 1 | In-region access to an address other than the original |
| type_err | output | 1 | Same-address access of the other type |
| ovf_err | output | 1 | Shadow access beyond MAX_SHADOW |

## Verification
On every cycle, the assertions check several invariants. The bypass flag only accompanies shadow tags. Tagged accesses only appear while ready is low. The index stays zero off shadow accesses and never exceeds the ceiling. At most one error pulse is raised at a time, and the shadow counter steps by one and clears on region boundaries. The bench's reference model is needed to show the rest: which access becomes the original, the exact index sequence across regions, the precedence of the address check over the type check, and the effects of a nested open or a stray close on later accesses.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  localparam logic [2:0] OPC_OTHER = 3'd0;
  localparam logic [2:0] OPC_OPEN  = 3'd1;
  localparam logic [2:0] OPC_CLOSE = 3'd2;
  localparam logic [2:0] OPC_LOAD  = 3'd3;
  localparam logic [2:0] OPC_STORE = 3'd4;

  typedef enum logic [1:0] {
    TAG_PLAIN  = 2'd0,
    TAG_ORIG   = 2'd1,
    TAG_SHADOW = 2'd2
  } acc_tag_t;
endpackage

// File: rtl/shreg_region_ctl.sv
module shreg_region_ctl (
  input  logic clk,
  input  logic rst,
  input  logic open_i,
  input  logic close_i,
  output logic region_o,
  output logic ready_o
);
  logic region_q;
  logic ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      region_q <= 1'b0;
      ready_q  <= 1'b1;
    end else if (open_i && !region_q) begin
      region_q <= 1'b1;
      ready_q  <= 1'b0;
    end else if (close_i && region_q) begin
      region_q <= 1'b0;
      ready_q  <= 1'b1;
    end
  end

  assign region_o = region_q;
  assign ready_o  = ready_q;

  AST_READY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (open_i && !region_q) |=> (!ready_q && region_q)); // R1
  AST_READY_SETS: assert property (@(posedge clk) disable iff (rst)
    (close_i && region_q && !open_i) |=> (ready_q && !region_q)); // R1
  AST_STRAY_CLOSE: assert property (@(posedge clk) disable iff (rst)
    (close_i && !region_q && !open_i) |=> ready_q); // R8
endmodule

// File: rtl/shreg_orig_capture.sv
module shreg_orig_capture #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          cap_i,
  input  logic [AW-1:0] addr_i,
  input  logic          store_i,
  output logic          have_o,
  output logic          addr_hit_o,
  output logic          type_hit_o
);
  logic          have_q;
  logic [AW-1:0] addr_q;
  logic          store_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q  <= 1'b0;
      addr_q  <= '0;
      store_q <= 1'b0;
    end else if (clr_i) begin
      have_q  <= 1'b0;
    end else if (cap_i) begin
      have_q  <= 1'b1;
      addr_q  <= addr_i;
      store_q <= store_i;
    end
  end

  assign have_o     = have_q;
  assign addr_hit_o = (addr_i == addr_q);
  assign type_hit_o = (store_i == store_q);

  AST_ORIG_HELD: assert property (@(posedge clk) disable iff (rst)
    (have_q && !clr_i) |=> ($stable(addr_q) && $stable(store_q) && have_q)); // R7
endmodule

// File: rtl/shreg_shadow_ctr.sv
module shreg_shadow_ctr #(
  parameter int MAX_SHADOW = 3,
  parameter int IW         = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [IW-1:0] cnt_o,
  output logic          at_max_o
);
  localparam logic [IW-1:0] CMAX = IW'(MAX_SHADOW);

  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && (cnt_q != CMAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = (cnt_q == CMAX);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !clr_i && !at_max_o) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R3
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0)); // R10
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CMAX); // R9
endmodule

// File: rtl/shadow_region_classifier.sv
module shadow_region_classifier #(
  parameter int AW         = 32,
  parameter int MAX_SHADOW = 3,
  localparam int IW        = $clog2(MAX_SHADOW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [2:0]    op_class,
  input  logic [AW-1:0] op_addr,
  output logic          acc_valid,
  output logic [1:0]    acc_tag,
  output logic [IW-1:0] shadow_idx,
  output logic          coh_bypass,
  output logic          ready,
  output logic          nest_err,
  output logic          addr_err,
  output logic          type_err,
  output logic          ovf_err
);
  import shreg_pkg::*;

  localparam logic [IW-1:0] IMAX = IW'(MAX_SHADOW);

  logic          is_mem, is_st, start_v, end_v;
  logic          region, have, addr_hit, type_hit;
  logic          first_acc, same_addr, shadow_hit, boundary;
  logic [IW-1:0] cnt;
  logic          at_max;
  acc_tag_t      tag_d;
  logic [IW-1:0] idx_d;

  assign is_mem  = op_valid && ((op_class == OPC_LOAD) || (op_class == OPC_STORE));
  assign is_st   = (op_class == OPC_STORE);
  assign start_v = op_valid && (op_class == OPC_OPEN);
  assign end_v   = op_valid && (op_class == OPC_CLOSE);

  assign boundary   = (start_v && !region) || (end_v && region);
  assign first_acc  = is_mem && region && !have;
  assign same_addr  = is_mem && region && have && addr_hit;
  assign shadow_hit = same_addr && type_hit;

  shreg_region_ctl u_region (
    .clk      (clk),
    .rst      (rst),
    .open_i   (start_v),
    .close_i  (end_v),
    .region_o (region),
    .ready_o  (ready)
  );

  shreg_orig_capture #(.AW(AW)) u_orig (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (boundary),
    .cap_i      (first_acc),
    .addr_i     (op_addr),
    .store_i    (is_st),
    .have_o     (have),
    .addr_hit_o (addr_hit),
    .type_hit_o (type_hit)
  );

  shreg_shadow_ctr #(.MAX_SHADOW(MAX_SHADOW), .IW(IW)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (boundary),
    .inc_i    (shadow_hit),
    .cnt_o    (cnt),
    .at_max_o (at_max)
  );

  always_comb begin
    tag_d = TAG_PLAIN;
    idx_d = '0;
    if (shadow_hit) begin
      tag_d = TAG_SHADOW;
      idx_d = at_max ? IMAX : cnt + 1'b1;
    end else if (first_acc) begin
      tag_d = TAG_ORIG;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid  <= 1'b0;
      acc_tag    <= TAG_PLAIN;
      shadow_idx <= '0;
      coh_bypass <= 1'b0;
      nest_err   <= 1'b0;
      addr_err   <= 1'b0;
      type_err   <= 1'b0;
      ovf_err    <= 1'b0;
    end else begin
      acc_valid  <= is_mem;
      acc_tag    <= tag_d;
      shadow_idx <= idx_d;
      coh_bypass <= shadow_hit;
      nest_err   <= start_v && region;
      addr_err   <= is_mem && region && have && !addr_hit;
      type_err   <= same_addr && !type_hit;
      ovf_err    <= shadow_hit && at_max;
    end
  end

  AST_BYPASS_SHADOW: assert property (@(posedge clk) disable iff (rst)
    coh_bypass |-> (acc_valid && acc_tag == TAG_SHADOW)); // R4
  AST_TAG_IN_REGION: assert property (@(posedge clk) disable iff (rst)
    (acc_tag != TAG_PLAIN) |-> !ready); // R2
  AST_IDX_OFF_SHADOW: assert property (@(posedge clk) disable iff (rst)
    (acc_tag != TAG_SHADOW) |-> (shadow_idx == '0)); // R3
  AST_OVF_AT_CEIL: assert property (@(posedge clk) disable iff (rst)
    ovf_err |-> (shadow_idx == IMAX && acc_tag == TAG_SHADOW)); // R9
  AST_NEST_OPEN: assert property (@(posedge clk) disable iff (rst)
    nest_err |-> !ready); // R7
  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (rst)
    $countones({nest_err, addr_err, type_err, ovf_err}) <= 1); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |-> (acc_tag == TAG_PLAIN && !addr_err && !type_err && !ovf_err)); // R11
endmodule

// File: tb/shadow_region_classifier_bench.sv
module shadow_region_classifier_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 32;
  localparam int MAXS = 3;
  localparam int IW   = 2;
  localparam logic [AW-1:0] ADDR_A = 32'h0000_1000;
  localparam logic [AW-1:0] ADDR_B = 32'h0000_1004;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic [2:0]    op_class = 3'd0;
  logic [AW-1:0] op_addr = '0;
  logic          acc_valid;
  logic [1:0]    acc_tag;
  logic [IW-1:0] shadow_idx;
  logic          coh_bypass, ready, nest_err, addr_err, type_err, ovf_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  bit       m_open, m_have, m_st, m_ready;
  logic [AW-1:0] m_addr;
  int       m_cnt;
  // expected outputs
  bit       e_vld, e_byp, e_nest, e_aerr, e_terr, e_ovf, have_exp;
  int       e_tag, e_idx;
  string    e_req;

  shadow_region_classifier #(.AW(AW), .MAX_SHADOW(MAXS)) u_shadow_region_classifier (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_class(op_class), .op_addr(op_addr),
    .acc_valid(acc_valid), .acc_tag(acc_tag), .shadow_idx(shadow_idx),
    .coh_bypass(coh_bypass), .ready(ready), .nest_err(nest_err),
    .addr_err(addr_err), .type_err(type_err), .ovf_err(ovf_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [9:0] pack_out(bit v, int t, int i, bit rd, bit n, bit a, bit ty, bit o);
    return {v, t[1:0], i[1:0], rd, n, a, ty, o};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_now();
    logic [9:0] act, exp;
    act = {acc_valid, acc_tag, shadow_idx, ready, nest_err, addr_err, type_err, ovf_err};
    exp = pack_out(e_vld, e_tag, e_idx, m_ready, e_nest, e_aerr, e_terr, e_ovf);
    chk(act == exp, e_req, 32'(act), 32'(exp));
    chk(coh_bypass == e_byp, "R4", 32'(coh_bypass), 32'(e_byp));
  endtask

  task automatic model(bit v, logic [2:0] c, logic [AW-1:0] a);
    e_vld = 0; e_tag = 0; e_idx = 0; e_byp = 0;
    e_nest = 0; e_aerr = 0; e_terr = 0; e_ovf = 0; e_req = "R11";
    if (v) begin
      case (c)
        3'd1: if (m_open) begin e_nest = 1; e_req = "R7"; end
              else begin m_open = 1; m_have = 0; m_cnt = 0; m_ready = 0; e_req = "R1"; end
        3'd2: if (m_open) begin m_open = 0; m_have = 0; m_cnt = 0; m_ready = 1; e_req = "R1"; end
              else e_req = "R8";
        3'd3, 3'd4: begin
          e_vld = 1;
          if (!m_open) e_req = "R10";
          else if (!m_have) begin
            m_have = 1; m_addr = a; m_st = (c == 3'd4); e_tag = 1; e_req = "R2";
          end else if (a != m_addr) begin e_aerr = 1; e_req = "R6"; end
          else if ((c == 3'd4) != m_st) begin e_terr = 1; e_req = "R5"; end
          else begin
            e_tag = 2; e_byp = 1;
            if (m_cnt == MAXS) begin e_ovf = 1; e_idx = MAXS; e_req = "R9"; end
            else begin m_cnt++; e_idx = m_cnt; e_req = "R3"; end
          end
        end
        default: e_req = "R11";
      endcase
    end
  endtask

  task automatic step(bit v, logic [2:0] c, logic [AW-1:0] a);
    @(negedge clk);
    if (have_exp) check_now();
    op_valid = v; op_class = c; op_addr = a;
    model(v, c, a);
    have_exp = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    m_open = 0; m_have = 0; m_st = 0; m_ready = 1; m_addr = '0; m_cnt = 0;
    have_exp = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state: R1 ready high, R11 nothing reported
    e_vld = 0; e_tag = 0; e_idx = 0; e_byp = 0; e_nest = 0; e_aerr = 0;
    e_terr = 0; e_ovf = 0; e_req = "R1";
    check_now();
    have_exp = 0;
    // directed corner cases
    step(1, 3'd2, '0);        // R8 stray close
    step(1, 3'd3, ADDR_A);    // R10 outside region plain
    step(1, 3'd1, '0);        // R1 open
    step(1, 3'd3, ADDR_A);    // R2 original load
    step(1, 3'd3, ADDR_A);    // R3 idx 1
    step(1, 3'd3, ADDR_A);    // R3 idx 2
    step(1, 3'd4, ADDR_A);    // R5 type mismatch
    step(1, 3'd4, ADDR_B);    // R6 address wins over type
    step(1, 3'd1, '0);        // R7 nested open
    step(1, 3'd3, ADDR_A);    // R3 idx 3 region kept
    step(1, 3'd3, ADDR_A);    // R9 overflow
    step(0, 3'd3, ADDR_A);    // R11 idle
    step(1, 3'd0, ADDR_A);    // R11 other class
    step(1, 3'd2, '0);        // R1 close
    step(1, 3'd1, '0);
    step(1, 3'd4, ADDR_B);    // R2 original store
    step(1, 3'd4, ADDR_B);    // R10 index restarts at 1
    step(1, 3'd2, '0);
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      logic [2:0] c;
      r = $urandom % 100;
      if (r < 8) c = 3'd1;
      else if (r < 16) c = 3'd2;
      else if (r < 22) c = 3'd0;
      else if (r < 70) c = 3'd3;
      else c = 3'd4;
      step(($urandom % 10) != 0, c, (($urandom % 4) == 0) ? ADDR_B : ADDR_A);
    end
    step(0, 3'd0, '0);
    @(negedge clk);
    check_now();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule